// File: doc/BRIEF.md
# Wide Byte-Masked Synchronous RAM

This block gives a 64-bit, 256-word synchronous RAM built from two 32-bit by 256-word memory halves placed side by side. The user side has active-high controls. The wrapper inverts chip select and write enable to drive the active-low controls of each half. It sends the same clock, address and controls to both halves. The low half gets write-data bits [31:0] and byte-mask bits [3:0]. The high half gets write-data bits [63:32] and byte-mask bits [7:4].

Each half has a combined read/write port and a spare read-only port. The spare port is tied off: its clock is held low, its select is held inactive and its address is held at zero. The project includes a behavioural model of each half, so it needs no outside macro.

Access is split across the two clock edges. The rising edge captures the address, the controls, the mask and the write data. The following falling edge performs the read or the write. A read result therefore shows on the output half a cycle after the rising edge that requested it.

Top module: `dual_bank_mem`

## Requirements
- R1: The memory holds 256 independent 64-bit words, selected by the 8-bit address. Writing one address leaves every other address unchanged.
- R2: Inputs are captured on the rising clock edge. Read data changes only at the falling edge that follows. Between that rising edge and that falling edge the output still shows the previous value.
- R3: A read of an address returns the last value written there. This includes a read issued in the cycle right after a write with all eight mask bits set to 1.
- R4: Write-mask bit i (0 to 7) enables writing byte lane i, which is data bits [8i+7:8i]. Mask bits [3:0] therefore cover the low 32 bits and mask bits [7:4] cover the high 32 bits.
- R5: During a write, every byte lane whose mask bit is 0 keeps its old contents. A write with mask 8'h00 changes nothing.
- R6: While chip select is low, the stored data and the read output do not change, whatever the values of write enable, address, mask and data.
- R7: In a write cycle (chip select 1, write enable 1), the read output keeps its previous value.
- R8: Driving the asynchronous active-low reset low forces the read output to zero. Reset does not clear the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge captures, falling edge accesses |
| rst_ni | input | 1 | Asynchronous active-low reset of the capture stage and read output |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | Write enable, active high (read when 0) |
| addr_i | input | 8 | Word address |
| wmask_i | input | 8 | Byte write mask, bit i enables lane i |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, updated on the falling edge |

## Verification
The assertions take three things for granted:
- The inputs are settled at each rising edge.
- No reset edge falls within an access.
- A partial write targets a word that was fully written earlier, so the unmasked-lane comparison compares defined data.

The stimulus changes inputs only a moment after each falling edge and fills all 256 words with full-mask writes before any partial write. Reset is applied only while the bench is idle with chip select low.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int unsigned LANE_W = 8;

  typedef struct packed {
    logic csb;
    logic web;
  } macro_ctl_t;
endpackage

// File: rtl/lane_merge.sv
module lane_merge #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = dbm_pkg::LANE_W
) (
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*LANE_W-1:0] old_i,
  input  logic [LANES*LANE_W-1:0] new_i,
  output logic [LANES*LANE_W-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*LANE_W +: LANE_W] =
      mask_i[l] ? new_i[l*LANE_W +: LANE_W] : old_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/sram_half.sv
module sram_half
  import dbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     csb0_ni,
  input  logic                     web0_ni,
  input  logic [DATA_W/LANE_W-1:0] wmask0_i,
  input  logic [ADDR_W-1:0]        addr0_i,
  input  logic [DATA_W-1:0]        din0_i,
  output logic [DATA_W-1:0]        dout0_o,
  input  logic                     clk1_i,
  input  logic                     csb1_ni,
  input  logic [ADDR_W-1:0]        addr1_i,
  output logic [DATA_W-1:0]        dout1_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  macro_ctl_t        cap_ctl_q;
  logic [LANES-1:0]  cap_mask_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_din_q;

  // rising edge: capture request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_ctl_q  <= '{csb: 1'b1, web: 1'b1};
      cap_mask_q <= '0;
      cap_addr_q <= '0;
      cap_din_q  <= '0;
    end else begin
      cap_ctl_q  <= '{csb: csb0_ni, web: web0_ni};
      cap_mask_q <= wmask0_i;
      cap_addr_q <= addr0_i;
      cap_din_q  <= din0_i;
    end
  end

  logic              wr_en, rd_en;
  logic [DATA_W-1:0] old_word, new_word;

  assign wr_en    = !cap_ctl_q.csb && !cap_ctl_q.web;
  assign rd_en    = !cap_ctl_q.csb &&  cap_ctl_q.web;
  assign old_word = mem_q[cap_addr_q];

  lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .mask_i   (cap_mask_q),
    .old_i    (old_word),
    .new_i    (cap_din_q),
    .merged_o (new_word)
  );

  // falling edge: perform access
  always_ff @(negedge clk_i) begin
    if (wr_en) mem_q[cap_addr_q] <= new_word;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dout0_o <= '0;
    else if (rd_en) dout0_o <= old_word;
  end

  // spare read-only port, same edge split
  logic              cap1_csb_q;
  logic [ADDR_W-1:0] cap1_addr_q;

  always_ff @(posedge clk1_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap1_csb_q  <= 1'b1;
      cap1_addr_q <= '0;
    end else begin
      cap1_csb_q  <= csb1_ni;
      cap1_addr_q <= addr1_i;
    end
  end

  always_ff @(negedge clk1_i or negedge rst_ni) begin
    if (!rst_ni)          dout1_o <= '0;
    else if (!cap1_csb_q) dout1_o <= mem_q[cap1_addr_q];
  end

  AST_WRITE_HOLDS_DOUT: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!cap_ctl_q.csb && !cap_ctl_q.web) |=> $stable(dout0_o)); // R7
  AST_DESEL_HOLDS_DOUT: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cap_ctl_q.csb |=> $stable(dout0_o)); // R6

  for (genvar l = 0; l < LANES; l++) begin : g_keep_chk
    AST_UNMASKED_LANE_KEPT: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (wr_en && !cap_mask_q[l]) |=>
      mem_q[$past(cap_addr_q)][l*LANE_W +: LANE_W] == $past(old_word[l*LANE_W +: LANE_W])); // R5
  end
endmodule

// File: rtl/dual_bank_mem.sv
module dual_bank_mem
  import dbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned HALVES = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cs_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [HALVES*HALF_W/LANE_W-1:0] wmask_i,
  input  logic [HALVES*HALF_W-1:0]        wdata_i,
  output logic [HALVES*HALF_W-1:0]        rdata_o
);
  localparam int unsigned DATA_W     = HALVES * HALF_W;
  localparam int unsigned HALF_LANES = HALF_W / LANE_W;

  macro_ctl_t  ctl_n;
  logic [HALF_W-1:0] spare_rd [HALVES];

  assign ctl_n = '{csb: ~cs_i, web: ~we_i};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    sram_half #(.ADDR_W(ADDR_W), .DATA_W(HALF_W)) u_half (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .csb0_ni  (ctl_n.csb),
      .web0_ni  (ctl_n.web),
      .wmask0_i (wmask_i[h*HALF_LANES +: HALF_LANES]),
      .addr0_i  (addr_i),
      .din0_i   (wdata_i[h*HALF_W +: HALF_W]),
      .dout0_o  (rdata_o[h*HALF_W +: HALF_W]),
      .clk1_i   (1'b0),
      .csb1_ni  (1'b1),
      .addr1_i  ({ADDR_W{1'b0}}),
      .dout1_o  (spare_rd[h])
    );

    // tied-off port must stay quiet
    AST_SPARE_PORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(spare_rd[h]));
  end

  AST_DESEL_RDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(rdata_o)); // R6
  AST_WRITE_RDATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i) |=> $stable(rdata_o)); // R7
  AST_FULL_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && $past(cs_i && we_i && (&wmask_i)) && addr_i == $past(addr_i))
    |=> rdata_o == $past(wdata_i, 2)); // R3

  initial begin
    AST_WIDTH_SPLIT: assert (DATA_W % LANE_W == 0 && HALF_W % LANE_W == 0); // R4
  end
endmodule

// File: tb/sim_dual_bank_mem.sv
module sim_dual_bank_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0, mask = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;

  int n_tests = 0, n_fail = 0;
  logic [63:0] ref_mem [256];
  logic [63:0] last_rd = '0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  dual_bank_mem u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wmask_i(mask), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n,
                                        input logic [7:0] m);
    logic [63:0] r = o;
    for (int l = 0; l < 8; l++) if (m[l]) r[l*8 +: 8] = n[l*8 +: 8];
    return r;
  endfunction

  // driver: one access per cycle, expected output pushed at the capturing edge
  task automatic do_op(input logic c, input logic w, input logic [7:0] a,
                       input logic [7:0] m, input logic [63:0] d, input string tag);
    logic [63:0] e;
    @(negedge clk); #1;
    cs = c; we = w; addr = a; mask = m; wdata = d;
    @(posedge clk); #1;
    if (c && !w) begin
      check("R2", rdata, last_rd);   // not yet updated before falling edge
      e = ref_mem[a];
      last_rd = e;
      tag_q.push_back(tag);
    end else begin
      e = last_rd;
      tag_q.push_back(c ? "R7" : "R6");
    end
    if (c && w) ref_mem[a] = merge(ref_mem[a], d, m);
    exp_q.push_back(e);
  endtask

  // monitor: compare after each falling edge
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  function automatic logic [63:0] pat(input int a);
    return {32'(a) * 32'h9E37_79B1, ~32'(a) ^ 32'h5A5A_0F0F};
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1 check("R8", rdata, 64'h0);

    // fill every word with a full mask
    for (int a = 0; a < 256; a++) do_op(1, 1, 8'(a), 8'hFF, pat(a), "R1");
    do_op(1, 0, 8'h00, 8'h00, 64'h0, "R1");
    do_op(1, 0, 8'hFF, 8'h00, 64'h0, "R1");
    do_op(1, 0, 8'h01, 8'h00, 64'h0, "R1");
    do_op(1, 0, 8'h80, 8'h00, 64'h0, "R1");

    // lane masks
    do_op(1, 1, 8'h10, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD, "R4");
    do_op(1, 0, 8'h10, 8'h00, 64'h0, "R4");
    do_op(1, 1, 8'h11, 8'hF0, 64'h1122_3344_5566_7788, "R4");
    do_op(1, 0, 8'h11, 8'h00, 64'h0, "R4");
    do_op(1, 1, 8'h12, 8'h81, 64'hFEDC_BA98_7654_3210, "R5");
    do_op(1, 0, 8'h12, 8'h00, 64'h0, "R5");
    do_op(1, 1, 8'h13, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    do_op(1, 0, 8'h13, 8'h00, 64'h0, "R5");
    for (int l = 0; l < 8; l++) begin
      do_op(1, 1, 8'h20 + 8'(l), 8'(1 << l), 64'h0123_4567_89AB_CDEF, "R4");
      do_op(1, 0, 8'h20 + 8'(l), 8'h00, 64'h0, "R4");
    end

    // deselected write and deselected read
    do_op(0, 1, 8'h30, 8'hFF, 64'hDEAD_BEEF_DEAD_BEEF, "R6");
    do_op(0, 0, 8'h31, 8'hFF, 64'h0, "R6");
    do_op(1, 0, 8'h30, 8'h00, 64'h0, "R6");

    // write then immediate read, plus write after read
    do_op(1, 1, 8'h40, 8'hFF, 64'hCAFE_F00D_1234_5678, "R3");
    do_op(1, 0, 8'h40, 8'h00, 64'h0, "R3");
    do_op(1, 1, 8'h41, 8'hFF, 64'h0BAD_C0DE_8765_4321, "R7");
    do_op(1, 0, 8'h40, 8'h00, 64'h0, "R1");
    do_op(1, 0, 8'h41, 8'h00, 64'h0, "R3");

    for (int i = 0; i < 400; i++)
      do_op(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
            {$urandom, $urandom}, "R3");

    // reset mid-run, stored words survive
    do_op(0, 0, 8'h00, 8'h00, 64'h0, "R6");
    wait (exp_q.size() == 0);
    @(negedge clk); #1 rst_n = 1'b0;
    #1 check("R8", rdata, 64'h0);
    @(posedge clk); #1 check("R8", rdata, 64'h0);
    @(negedge clk); #1 rst_n = 1'b1;
    last_rd = '0;
    do_op(1, 0, 8'h12, 8'h00, 64'h0, "R8");
    do_op(1, 0, 8'hFF, 8'h00, 64'h0, "R8");

    repeat (2) do_op(0, 0, 8'h00, 8'h00, 64'h0, "R6");
    wait (exp_q.size() == 0);
    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule